// File: doc/BRIEF.md
# Split-tag direct-mapped TLB

This block is a small translation cache that sits between a core's address generation and memory. It maps a virtual page to a physical page base through a direct-mapped table whose slot is chosen by the low bits of the virtual page number. It keeps three tag arrays: one for instruction fetch, one for loads and one for stores. All three share one physical-page data array, so a page can be valid for one kind of access and still miss for another until that kind has been refilled.

A request is accepted when `reqReady` is high. A hit answers one cycle later. On a miss in bare mode, the page base is the virtual address with its offset cleared, and the answer also comes one cycle later without a walk. On a miss in translated mode, the block raises a walk request toward an external page-table walker and holds `reqReady` low. It answers in the cycle after the walker reports done.

Every resulting base is compared against a memory-size limit. A base at or above the limit gives an access fault. A fault reported by the walker gives a page fault. Neither kind of fault changes any tag. A flush input invalidates the whole table.

Top module: `tlb_split_direct`

## Requirements
- R1: After reset, and in the cycle after `flushReq` is high, every tag of all three arrays holds the all-ones invalid value, so the next lookup misses, including one at virtual page number all-ones.
- R2: The slot index is the virtual page number modulo ENTRIES (its low log2(ENTRIES) bits), and the full page number is the tag: a page at the same slot with different upper bits misses.
- R3: A hit accepted at a clock edge gives, after that edge, `respValid`=1, `respHit`=1 and `respPaddr` = {stored page base, address offset}, with no walk request.
- R4: The three access kinds are tracked apart. `reqType` encodes load=0, store=1, fetch=2, and 3 acts as a load. A refill writes the new page number only into the tag array of the requesting kind.
- R5: On a refill, each sibling tag at that slot that differs from the new page number is set invalid. Siblings equal to it stay valid and share the new page base.
- R6: In bare mode (`bareMode`=1), a miss takes the address with its low 12 offset bits cleared as the page base and answers after one edge with no walk request.
- R7: In translated mode, a miss raises `walkReq` with `walkVpn` and `walkType` from the request and holds `reqReady` low until `walkDone`. The response is visible after the edge that samples `walkDone`.
- R8: `walkSuper` is 1 when the effective privilege is non-zero. The effective privilege is `privPrev` for non-fetch accesses with `mprv`=1, and `privCur` otherwise.
- R9: If the resulting page base is at or above `memSize`, the response carries `respAccFault`=1 with `respType` equal to the request's type, and no tag changes.
- R10: If the walker reports `walkFault` with `walkDone`, the response carries `respPageFault`=1 and no tag changes.
- R11: On a refill response, `respPaddr` is the page base (`walkBase` or the bare base, with bits 11:0 ignored) plus the request's 12 offset bits.
- R12: A flush in the same cycle as a refill wins: the refilled page misses afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flushReq | input | 1 | Invalidate all tags |
| reqValid | input | 1 | Lookup request valid |
| reqReady | output | 1 | Block can accept a request |
| reqAddr | input | XLEN | Virtual address |
| reqType | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| bareMode | input | 1 | Translation off |
| mprv | input | 1 | Data accesses use the previous privilege |
| privCur | input | 2 | Current privilege level |
| privPrev | input | 2 | Previous privilege level |
| memSize | input | XLEN | Memory-size limit for page bases |
| walkReq | output | 1 | Walk requested |
| walkVpn | output | XLEN-12 | Page number to walk |
| walkType | output | 2 | Access kind of the walk |
| walkSuper | output | 1 | Walk runs with supervisor rights |
| walkDone | input | 1 | Walker result valid |
| walkFault | input | 1 | Walker found no valid mapping |
| walkBase | input | XLEN | Physical page base from walker |
| respValid | output | 1 | Response valid for one cycle |
| respHit | output | 1 | Response came from a hit |
| respAccFault | output | 1 | Page base beyond memory size |
| respPageFault | output | 1 | Walker fault |
| respType | output | 2 | Access kind of the response |
| respPaddr | output | XLEN | Physical address (zero on faults) |

## Verification
The hardest state to reach is a slot whose three tags disagree: for example, load and fetch tags valid for one page while the store tag holds another page or is invalid. Reaching it takes refills of different kinds at the same slot, interleaved with conflicting pages. The directed part builds this on purpose: it fills a load, then a fetch of the same page, then a conflicting page at the same slot. The random part draws pages from a small pool of upper bits over all sixteen slots, so conflicts, sibling invalidation and shared-data hits recur often. The same flush input is also driven in the exact cycle of a bare refill to show that the flush wins.

// File: rtl/tlb_split_pkg.sv
package tlb_split_pkg;

  localparam logic [1:0] KIND_LOAD  = 2'd0;
  localparam logic [1:0] KIND_STORE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  // Map an access kind onto its tag array; kind 3 shares the load array.
  function automatic logic [1:0] slotOf(input logic [1:0] kind);
    case (kind)
      KIND_FETCH: slotOf = 2'd2;
      KIND_STORE: slotOf = 2'd1;
      default:    slotOf = 2'd0;
    endcase
  endfunction

  typedef enum logic {ST_IDLE, ST_WALK} ctrlState_e;

  typedef struct packed {
    logic capture;       // latch the incoming request
    logic useWalk;       // select latched request and walker base
    logic refill;        // write tags and data at the selected slot
    logic flush;         // invalidate every tag
    logic sendHit;
    logic sendFill;
    logic sendAccFault;
    logic sendPageFault;
  } tlbStrobes_t;

endpackage

// File: rtl/tlb_split_dpath.sv
module tlb_split_dpath
  import tlb_split_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int PG_SHIFT = 12,
  parameter int ENTRIES  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  tlbStrobes_t            stb,
  input  logic [XLEN-1:0]        reqAddr,
  input  logic [1:0]             reqType,
  input  logic                   mprv,
  input  logic [1:0]             privCur,
  input  logic [1:0]             privPrev,
  input  logic [XLEN-1:0]        walkBase,
  input  logic [XLEN-1:0]        memSize,
  output logic                   hitNow,
  output logic                   overLimit,
  output logic [XLEN-PG_SHIFT-1:0] walkVpn,
  output logic [1:0]             walkType,
  output logic                   walkSuper,
  output logic                   respValid,
  output logic                   respHit,
  output logic                   respAccFault,
  output logic                   respPageFault,
  output logic [1:0]             respType,
  output logic [XLEN-1:0]        respPaddr
);

  localparam int VPN_W = XLEN - PG_SHIFT;
  localparam int TAG_W = VPN_W + 1;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int NSLOT = 3;
  localparam logic [TAG_W-1:0] TAG_NONE = '1;

  // Incoming request fields
  logic [VPN_W-1:0]    inVpn;
  logic [IDX_W-1:0]    inIdx;
  logic [PG_SHIFT-1:0] inOff;
  logic [1:0]          inSlot;
  logic [1:0]          effPriv;
  logic                inSuper;

  assign inVpn   = reqAddr[XLEN-1:PG_SHIFT];
  assign inIdx   = inVpn[IDX_W-1:0];
  assign inOff   = reqAddr[PG_SHIFT-1:0];
  assign inSlot  = slotOf(reqType);
  assign effPriv = (reqType != KIND_FETCH && mprv) ? privPrev : privCur;
  assign inSuper = (effPriv != 2'd0);

  // Latched request for the walk path
  logic [VPN_W-1:0]    latVpn;
  logic [PG_SHIFT-1:0] latOff;
  logic [1:0]          latType;
  logic                latSuper;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latVpn   <= '0;
      latOff   <= '0;
      latType  <= KIND_LOAD;
      latSuper <= 1'b0;
    end else if (stb.capture) begin
      latVpn   <= inVpn;
      latOff   <= inOff;
      latType  <= reqType;
      latSuper <= inSuper;
    end
  end

  assign walkVpn   = latVpn;
  assign walkType  = latType;
  assign walkSuper = latSuper;

  // Refill source selection
  logic [VPN_W-1:0]    selVpn;
  logic [IDX_W-1:0]    selIdx;
  logic [PG_SHIFT-1:0] selOff;
  logic [1:0]          selType;
  logic [1:0]          selSlot;
  logic [TAG_W-1:0]    newTag;
  logic [XLEN-1:0]     candBase;
  logic [VPN_W-1:0]    candPpn;

  assign selVpn   = stb.useWalk ? latVpn  : inVpn;
  assign selOff   = stb.useWalk ? latOff  : inOff;
  assign selType  = stb.useWalk ? latType : reqType;
  assign selIdx   = selVpn[IDX_W-1:0];
  assign selSlot  = slotOf(selType);
  assign newTag   = {1'b0, selVpn};
  assign candPpn  = stb.useWalk ? walkBase[XLEN-1:PG_SHIFT] : inVpn;
  assign candBase = {candPpn, {PG_SHIFT{1'b0}}};
  assign overLimit = (candBase >= memSize);

  // One tag array per access kind
  logic [3:0] slotHit;
  assign slotHit[3] = 1'b0;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [TAG_W-1:0] tagMem [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int e = 0; e < ENTRIES; e++) tagMem[e] <= TAG_NONE;
      end else if (stb.flush) begin
        for (int e = 0; e < ENTRIES; e++) tagMem[e] <= TAG_NONE;
      end else if (stb.refill) begin
        if (selSlot == 2'(s)) begin
          tagMem[selIdx] <= newTag;
        end else if (tagMem[selIdx] != newTag) begin
          tagMem[selIdx] <= TAG_NONE;
        end
      end
    end

    assign slotHit[s] = (tagMem[inIdx] == {1'b0, inVpn});
  end

  assign hitNow = slotHit[inSlot];

  // Shared physical page array
  logic [VPN_W-1:0] dataMem [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) dataMem[e] <= '0;
    end else if (stb.refill) begin
      dataMem[selIdx] <= candPpn;
    end
  end

  // Registered response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      respValid     <= 1'b0;
      respHit       <= 1'b0;
      respAccFault  <= 1'b0;
      respPageFault <= 1'b0;
      respType      <= KIND_LOAD;
      respPaddr     <= '0;
    end else begin
      respValid     <= stb.sendHit | stb.sendFill | stb.sendAccFault | stb.sendPageFault;
      respHit       <= stb.sendHit;
      respAccFault  <= stb.sendAccFault;
      respPageFault <= stb.sendPageFault;
      respType      <= selType;
      if (stb.sendHit)       respPaddr <= {dataMem[inIdx], inOff};
      else if (stb.sendFill) respPaddr <= {candPpn, selOff};
      else                   respPaddr <= '0;
    end
  end

endmodule

// File: rtl/tlb_split_ctrl.sv
module tlb_split_ctrl
  import tlb_split_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        flushReq,
  input  logic        bareMode,
  input  logic        hitNow,
  input  logic        overLimit,
  input  logic        walkDone,
  input  logic        walkFault,
  output tlbStrobes_t stb,
  output logic        reqReady,
  output logic        walkReq
);

  ctrlState_e state, stateNext;

  always_comb begin
    stb       = '0;
    stb.flush = flushReq;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stb.capture = 1'b1;
          if (hitNow) begin
            stb.sendHit = 1'b1;
          end else if (bareMode) begin
            if (overLimit) begin
              stb.sendAccFault = 1'b1;
            end else begin
              stb.refill   = 1'b1;
              stb.sendFill = 1'b1;
            end
          end else begin
            stateNext = ST_WALK;
          end
        end
      end
      ST_WALK: begin
        stb.useWalk = 1'b1;
        if (walkDone) begin
          stateNext = ST_IDLE;
          if (walkFault) begin
            stb.sendPageFault = 1'b1;
          end else if (overLimit) begin
            stb.sendAccFault = 1'b1;
          end else begin
            stb.refill   = 1'b1;
            stb.sendFill = 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  assign reqReady = (state == ST_IDLE);
  assign walkReq  = (state == ST_WALK);

endmodule

// File: rtl/tlb_split_direct.sv
module tlb_split_direct
  import tlb_split_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int PG_SHIFT = 12,
  parameter int ENTRIES  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flushReq,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic [XLEN-1:0]          reqAddr,
  input  logic [1:0]               reqType,
  input  logic                     bareMode,
  input  logic                     mprv,
  input  logic [1:0]               privCur,
  input  logic [1:0]               privPrev,
  input  logic [XLEN-1:0]          memSize,
  output logic                     walkReq,
  output logic [XLEN-PG_SHIFT-1:0] walkVpn,
  output logic [1:0]               walkType,
  output logic                     walkSuper,
  input  logic                     walkDone,
  input  logic                     walkFault,
  input  logic [XLEN-1:0]          walkBase,
  output logic                     respValid,
  output logic                     respHit,
  output logic                     respAccFault,
  output logic                     respPageFault,
  output logic [1:0]               respType,
  output logic [XLEN-1:0]          respPaddr
);

  tlbStrobes_t stb;
  logic        hitNow;
  logic        overLimit;

  tlb_split_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqValid  (reqValid),
    .flushReq  (flushReq),
    .bareMode  (bareMode),
    .hitNow    (hitNow),
    .overLimit (overLimit),
    .walkDone  (walkDone),
    .walkFault (walkFault),
    .stb       (stb),
    .reqReady  (reqReady),
    .walkReq   (walkReq)
  );

  tlb_split_dpath #(
    .XLEN     (XLEN),
    .PG_SHIFT (PG_SHIFT),
    .ENTRIES  (ENTRIES)
  ) u_dpath (
    .clk           (clk),
    .rst_n         (rst_n),
    .stb           (stb),
    .reqAddr       (reqAddr),
    .reqType       (reqType),
    .mprv          (mprv),
    .privCur       (privCur),
    .privPrev      (privPrev),
    .walkBase      (walkBase),
    .memSize       (memSize),
    .hitNow        (hitNow),
    .overLimit     (overLimit),
    .walkVpn       (walkVpn),
    .walkType      (walkType),
    .walkSuper     (walkSuper),
    .respValid     (respValid),
    .respHit       (respHit),
    .respAccFault  (respAccFault),
    .respPageFault (respPageFault),
    .respType      (respType),
    .respPaddr     (respPaddr)
  );

endmodule

// File: rtl/tlb_split_direct_chk.sv
module tlb_split_direct_chk #(
  parameter int VPN_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reqValid,
  input logic             reqReady,
  input logic             bareMode,
  input logic             walkReq,
  input logic [VPN_W-1:0] walkVpn,
  input logic             walkDone,
  input logic             respValid,
  input logic             respHit,
  input logic             respAccFault,
  input logic             respPageFault
);

  // R7: a pending walk keeps its request and page number until done
  assert_walk_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (walkReq && !walkDone) |=> (walkReq && $stable(walkVpn)));

  // R7: no new request is accepted while walking
  assert_busy_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    walkReq |-> !reqReady);

  // R7: walker completion produces a response in the next cycle
  assert_done_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (walkReq && walkDone) |=> respValid);

  // R3: a response follows only an accepted request or a finished walk
  assert_resp_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |-> ($past(reqValid && reqReady) || $past(walkReq && walkDone)));

  // R6: a bare-mode request never starts a walk
  assert_bare_nowalk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady && bareMode) |=> !walkReq);

  // R9: outcome flags are exclusive and appear only with a response
  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0({respHit, respAccFault, respPageFault}) &&
     (respValid || !(respHit || respAccFault || respPageFault))));

endmodule

bind tlb_split_direct tlb_split_direct_chk #(.VPN_W(XLEN - PG_SHIFT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reqValid      (reqValid),
  .reqReady      (reqReady),
  .bareMode      (bareMode),
  .walkReq       (walkReq),
  .walkVpn       (walkVpn),
  .walkDone      (walkDone),
  .respValid     (respValid),
  .respHit       (respHit),
  .respAccFault  (respAccFault),
  .respPageFault (respPageFault)
);

// File: tb/tlb_split_direct_tb.sv
`timescale 1ns/1ps
module tlb_split_direct_tb;

  localparam int XLEN = 32;
  localparam int ENT  = 16;
  localparam logic [31:0] MEMSZ = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flushReq = 1'b0, reqValid = 1'b0, reqReady;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqType = '0;
  logic        bareMode = 1'b0, mprv = 1'b0;
  logic [1:0]  privCur = '0, privPrev = '0;
  logic [31:0] memSize = MEMSZ;
  logic        walkReq, walkSuper;
  logic [19:0] walkVpn;
  logic [1:0]  walkType;
  logic        walkDone = 1'b0, walkFault = 1'b0;
  logic [31:0] walkBase = '0;
  logic        respValid, respHit, respAccFault, respPageFault;
  logic [1:0]  respType;
  logic [31:0] respPaddr;

  always #10 clk = ~clk;

  tlb_split_direct u_dut (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [20:0] mTag [3][ENT];
  logic [19:0] mData [ENT];

  function automatic int slotTb(input logic [1:0] k);
    return (k == 2'd2) ? 2 : (k == 2'd1) ? 1 : 0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic modelFlush();
    for (int s = 0; s < 3; s++)
      for (int e = 0; e < ENT; e++) mTag[s][e] = '1;
  endtask

  task automatic modelRefill(input logic [19:0] vpn, input logic [1:0] k,
                             input logic [19:0] ppn);
    int idx = int'(vpn[3:0]);
    for (int s = 0; s < 3; s++) begin
      if (s == slotTb(k)) mTag[s][idx] = {1'b0, vpn};
      else if (mTag[s][idx] != {1'b0, vpn}) mTag[s][idx] = '1;
    end
    mData[idx] = ppn;
  endtask

  task automatic doFlush();
    @(negedge clk) flushReq = 1'b1;
    @(negedge clk) flushReq = 1'b0;
    modelFlush();
  endtask

  task automatic doAccess(input string tag, input logic [31:0] addr,
                          input logic [1:0] k, input bit bare,
                          input bit mp, input logic [1:0] pc, input logic [1:0] pp,
                          input bit wf, input logic [31:0] base, input int delay,
                          input bit flushWith);
    logic [19:0] vpn = addr[31:12];
    int idx = int'(addr[15:12]);
    bit expHit = (mTag[slotTb(k)][idx] == {1'b0, vpn});
    logic [3:0]  expFlags;
    logic [31:0] expPa = '0;
    logic [1:0]  ep;
    @(negedge clk);
    chk(reqReady == 1'b1, tag, "R7 ready while idle", 64'(reqReady), 1);
    reqValid = 1'b1; reqAddr = addr; reqType = k; bareMode = bare;
    mprv = mp; privCur = pc; privPrev = pp; flushReq = flushWith;
    @(negedge clk);
    reqValid = 1'b0; flushReq = 1'b0;
    if (expHit) begin
      expFlags = 4'b1100;
      expPa = {mData[idx], addr[11:0]};
      chk(walkReq == 1'b0, tag, "R3 no walk on hit", 64'(walkReq), 0);
    end else if (bare) begin
      chk(walkReq == 1'b0, tag, "R6 no walk in bare", 64'(walkReq), 0);
      if ({vpn, 12'h000} >= MEMSZ) expFlags = 4'b1010;
      else begin
        expFlags = 4'b1000;
        expPa = addr;
        modelRefill(vpn, k, vpn);
      end
    end else begin
      ep = (k != 2'd2 && mp) ? pp : pc;
      chk(walkReq == 1'b1, tag, "R7 walk raised", 64'(walkReq), 1);
      chk(walkVpn == vpn && walkType == k, tag, "R7 walk vpn/type",
          {walkType, 12'h0, walkVpn}, {k, 12'h0, vpn});
      chk(walkSuper == (ep != 2'd0), tag, "R8 walkSuper", 64'(walkSuper), 64'(ep != 0));
      chk(respValid == 1'b0 && reqReady == 1'b0, tag, "R7 busy",
          {respValid, reqReady}, 0);
      for (int d = 0; d < delay; d++) begin
        @(negedge clk);
        chk(walkReq == 1'b1 && respValid == 1'b0, tag, "R7 hold",
            {walkReq, respValid}, 2'b10);
      end
      walkDone = 1'b1; walkFault = wf; walkBase = base;
      @(negedge clk);
      walkDone = 1'b0; walkFault = 1'b0;
      if (wf) expFlags = 4'b1001;
      else if ({base[31:12], 12'h000} >= MEMSZ) expFlags = 4'b1010;
      else begin
        expFlags = 4'b1000;
        expPa = {base[31:12], addr[11:0]};
        modelRefill(vpn, k, base[31:12]);
      end
    end
    if (flushWith) modelFlush();
    chk({respValid, respHit, respAccFault, respPageFault} == expFlags, tag,
        "R9 R10 response flags", 64'({respValid, respHit, respAccFault, respPageFault}),
        64'(expFlags));
    chk(respPaddr == expPa, tag, "R11 paddr", 64'(respPaddr), 64'(expPa));
    chk(respType == k, tag, "R9 respType", 64'(respType), 64'(k));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] uppers [4];
    uppers[0] = 16'h0001; uppers[1] = 16'h0002; uppers[2] = 16'h7FF0; uppers[3] = 16'h9000;
    void'($urandom(32'd2024));
    modelFlush();
    for (int e = 0; e < ENT; e++) mData[e] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(reqReady == 1'b1 && walkReq == 1'b0 && respValid == 1'b0, "R1", "reset outputs",
        {reqReady, walkReq, respValid}, 3'b100);
    // R1: page number all-ones misses after reset
    doAccess("R1", 32'hFFFF_F123, 2'd0, 0, 0, 2'd1, 2'd0, 0, 32'h0001_0000, 1, 0);
    // R3: load fill then hit
    doAccess("R11", 32'h0001_2345, 2'd0, 0, 0, 2'd1, 2'd0, 0, 32'h0003_4ABC, 0, 0);
    doAccess("R3", 32'h0001_2FFF, 2'd0, 0, 0, 2'd1, 2'd0, 0, 32'h0, 0, 0);
    // R4: fetch and store keep separate tags
    doAccess("R4", 32'h0001_2010, 2'd2, 0, 0, 2'd1, 2'd0, 0, 32'h0005_6000, 2, 0);
    // R5: load sibling still valid, sees new shared base
    doAccess("R5", 32'h0001_2020, 2'd0, 0, 0, 2'd1, 2'd0, 0, 32'h0, 0, 0);
    doAccess("R4", 32'h0001_2030, 2'd1, 0, 0, 2'd1, 2'd0, 0, 32'h0007_7000, 0, 0);
    // R2: conflicting page at same slot, then the old page misses
    doAccess("R2", 32'h0002_2040, 2'd0, 0, 0, 2'd1, 2'd0, 0, 32'h0008_8000, 0, 0);
    doAccess("R2", 32'h0001_2050, 2'd0, 0, 0, 2'd1, 2'd0, 0, 32'h0009_9000, 0, 0);
    // R5: fetch tag for old page was invalidated by the conflicting refill
    doAccess("R5", 32'h0001_2060, 2'd2, 0, 0, 2'd1, 2'd0, 0, 32'h000A_A000, 0, 0);
    // R6: bare miss then hit
    doAccess("R6", 32'h0007_8ABC, 2'd0, 1, 0, 2'd3, 2'd0, 0, 32'h0, 0, 0);
    doAccess("R6", 32'h0007_8ABD, 2'd0, 1, 0, 2'd3, 2'd0, 0, 32'h0, 0, 0);
    // R9: bare base over the limit, repeated, never cached
    doAccess("R9", 32'h9000_0004, 2'd1, 1, 0, 2'd3, 2'd0, 0, 32'h0, 0, 0);
    doAccess("R9", 32'h9000_0008, 2'd1, 1, 0, 2'd3, 2'd0, 0, 32'h0, 0, 0);
    // R9: walker base over the limit
    doAccess("R9", 32'h0003_3000, 2'd2, 0, 0, 2'd1, 2'd0, 0, 32'hA000_0000, 1, 0);
    doAccess("R9", 32'h0003_3004, 2'd2, 0, 0, 2'd1, 2'd0, 0, 32'h0000_1000, 0, 0);
    // R10: walker fault leaves no tag
    doAccess("R10", 32'h0004_4000, 2'd0, 0, 0, 2'd1, 2'd0, 1, 32'h0, 0, 0);
    doAccess("R10", 32'h0004_4008, 2'd0, 0, 0, 2'd1, 2'd0, 0, 32'h0000_2000, 0, 0);
    // R8: effective privilege
    doAccess("R8", 32'h0005_5000, 2'd2, 0, 1, 2'd0, 2'd1, 0, 32'h0000_3000, 0, 0);
    doAccess("R8", 32'h0005_6000, 2'd0, 0, 1, 2'd0, 2'd1, 0, 32'h0000_4000, 0, 0);
    doAccess("R8", 32'h0005_7000, 2'd1, 0, 0, 2'd0, 2'd3, 0, 32'h0000_5000, 0, 0);
    // R1: flush, then filled page misses
    doFlush();
    doAccess("R1", 32'h0005_6010, 2'd0, 0, 0, 2'd1, 2'd0, 0, 32'h0000_6000, 0, 0);
    // R12: flush in the same cycle as a bare refill
    doAccess("R12", 32'h0006_1000, 2'd0, 1, 0, 2'd3, 2'd0, 0, 32'h0, 0, 1);
    doAccess("R12", 32'h0006_1004, 2'd0, 1, 0, 2'd3, 2'd0, 0, 32'h0, 0, 0);
    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a, b;
      logic [1:0] k;
      a = {uppers[$urandom % 4], 4'($urandom), 12'($urandom)};
      k = 2'($urandom % 4);
      b = ($urandom % 8 == 0) ? {4'hC, 28'($urandom)} : {8'h00, 24'($urandom)};
      if ($urandom % 40 == 0) doFlush();
      doAccess("R4", a, k, ($urandom % 4 == 0), 1'($urandom), 2'($urandom), 2'($urandom),
               ($urandom % 10 == 0), b, int'($urandom % 3), 0);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule